// File: doc/BRIEF.md
# I2C Target Controller with Backend Event Handshake

This block is the target (slave) side of an I2C bus. It samples the SCL and SDA lines through two-flop synchronizers, finds start, repeated start and stop conditions, and compares each received address with a programmable 7-bit own address. It never drives the clock or the bus as a controller. Instead it turns bus activity into a short series of events for a local backend, and it waits for the backend's answer to each one.

Every event except stop uses a valid/ready handshake. The block holds `evt_valid` high with a stable code and write byte until the backend pulses `bk_ready`. The backend returns `bk_err` to refuse and `bk_rdata` to supply transmit data. While an answer is outstanding and SCL is low, the block holds SCL low, so the backend may take as many cycles as it needs. SDA is driven open-drain: `sda_oe` high pulls the line low. The same holds for SCL through `scl_oe`. On reads the block asks for the following byte as soon as the current byte begins to shift out.

Top module: `i2c_evt_target`

## Requirements
- R1: When the own address arrives with the R/W bit at 0, the block raises event code 0 (write requested) before any data bit is clocked, and it ACKs the address by pulling SDA low during the ninth clock.
- R2: A matching address is ACKed whether the backend answers event 0 with or without `bk_err`. A non-matching address gets no ACK and raises no event, and the block ignores the bus until the next start.
- R3: When the backend answers event 0 with `bk_err`=1, every data byte of that write is NACKed (SDA released on the ninth clock) and raises no event, until the next stop or start.
- R4: In an accepted write, each received byte raises event code 2 (write received) with the byte on `evt_wdata`, held stable until `bk_ready`. `bk_err`=0 ACKs the byte and `bk_err`=1 NACKs it.
- R5: When the own address arrives with the R/W bit at 1, the block raises event code 1 (read requested), ACKs the address, and transmits the returned `bk_rdata` MSB first.
- R6: On the falling SCL edge that starts each transmitted byte, the block raises event code 3 (read processed) without waiting for the controller's acknowledge. The byte returned is sent next if the controller ACKs.
- R7: When the controller NACKs a read byte, the block releases SDA and raises no further event before the stop. The prefetched byte is discarded, and the next read sends the byte returned for its own event 1.
- R8: A stop condition at any bit position returns the block to idle with SDA and SCL released. If the block was addressed since the previous stop, it pulses `evt_valid` for one cycle with event code 4 and expects no `bk_ready`.
- R9: A repeated start during a transfer returns the block to address reception without a code 4 event.
- R10: From a handshake event until `bk_ready`, once SCL has been seen low, the block holds SCL low, and it does not hold SCL at any other time.
- R11: After reset, `sda_oe`, `scl_oe` and `evt_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | High pulls SCL low (clock stretch) |
| sda_oe | output | 1 | High pulls SDA low (ACK or a 0 data bit) |
| own_addr | input | 7 | Own 7-bit target address |
| evt_valid | output | 1 | Event present |
| evt_code | output | 3 | 0 write requested, 1 read requested, 2 write received, 3 read processed, 4 stop |
| evt_wdata | output | 8 | Received byte for event 2 |
| bk_ready | input | 1 | Backend answer strobe, one cycle |
| bk_err | input | 1 | Backend refuses (events 0 and 2) |
| bk_rdata | input | 8 | Transmit byte (events 1 and 3) |

## Verification
Line changes reach the control logic three clock cycles after they happen: two synchronizer flops plus the edge register. SDA from the block therefore changes a few cycles after SCL falls, and an event appears a few cycles after the SCL edge that completes a byte. The bench model of the controller holds each SCL phase for twelve cycles. It samples SDA only at the end of the high phase, after waiting out any stretch, so every sample falls well after the block's latency. Backend events are logged on the handshake cycle, and the stop pulse on its single cycle. The log is compared with the expected sequence only after the stop has settled.

// File: rtl/i2c_evt_target.sv
module i2c_evt_target (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  output logic       evt_valid,
  output logic [2:0] evt_code,
  output logic [7:0] evt_wdata,
  input  logic       bk_ready,
  input  logic       bk_err,
  input  logic [7:0] bk_rdata
);
  localparam logic [2:0] EV_WREQ = 3'd0, EV_RREQ = 3'd1, EV_WRCV = 3'd2,
                         EV_RPROC = 3'd3, EV_STOP = 3'd4;
  typedef enum logic [2:0] {IDLE, ADDR, WDAT, ACKP, RDAT, HACK} st_t;

  st_t        st;
  logic [2:0] scl_s, sda_s;
  logic [3:0] cnt;
  logic [7:0] sh, tx, nxt;
  logic [2:0] code;
  logic       rw, is_addr, fell, ackd, wr_ref, sel, req, hold, stop_p, hack;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire cond_start = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire cond_stop  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];
  wire resp = req & bk_ready;
  wire pend = req & ~bk_ready;
  wire ack_now = resp ? ~((code == EV_WRCV) & bk_err) : ackd;

  assign evt_valid = req | stop_p;
  assign evt_code  = stop_p ? EV_STOP : code;
  assign evt_wdata = sh;
  assign scl_oe    = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; tx <= '0; nxt <= '0; code <= EV_WREQ;
      rw <= 1'b0; is_addr <= 1'b0; fell <= 1'b0; ackd <= 1'b0; wr_ref <= 1'b0;
      sel <= 1'b0; req <= 1'b0; hold <= 1'b0; stop_p <= 1'b0; hack <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      stop_p <= 1'b0;
      if (resp) begin
        req  <= 1'b0;
        hold <= 1'b0;
        case (code)
          EV_WREQ:  wr_ref <= bk_err;
          EV_RREQ:  tx <= bk_rdata;
          EV_RPROC: nxt <= bk_rdata;
          EV_WRCV:  ackd <= ~bk_err;
          default: ;
        endcase
        if (st == ACKP && fell) sda_oe <= ack_now;
      end
      if (cond_start) begin
        st <= ADDR; cnt <= '0; req <= 1'b0; hold <= 1'b0; sda_oe <= 1'b0;
      end else if (cond_stop) begin
        st <= IDLE; req <= 1'b0; hold <= 1'b0; sda_oe <= 1'b0;
        wr_ref <= 1'b0; sel <= 1'b0; stop_p <= sel;
      end else begin
        case (st)
          ADDR, WDAT: if (scl_rise) begin
            sh  <= {sh[6:0], sda_s[1]};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              fell <= 1'b0;
              if (st == ADDR) begin
                if (sh[6:0] == own_addr) begin
                  st <= ACKP; is_addr <= 1'b1; rw <= sda_s[1]; ackd <= 1'b1;
                  req <= 1'b1; code <= sda_s[1] ? EV_RREQ : EV_WREQ;
                  sel <= 1'b1; wr_ref <= 1'b0;
                end else begin
                  st <= IDLE;
                end
              end else begin
                st <= ACKP; is_addr <= 1'b0;
                if (wr_ref) ackd <= 1'b0;
                else begin req <= 1'b1; code <= EV_WRCV; end
              end
            end
          end
          ACKP: if (scl_fall) begin
            if (!fell) begin
              fell <= 1'b1;
              if (pend) hold <= 1'b1;
              else sda_oe <= ack_now;
            end else begin
              cnt <= '0;
              if (rw) begin
                st <= RDAT; sda_oe <= ~tx[7];
                req <= 1'b1; code <= EV_RPROC; hold <= 1'b1;
              end else begin
                st <= WDAT; sda_oe <= 1'b0;
              end
            end
          end
          RDAT: if (scl_rise) cnt <= cnt + 4'd1;
                else if (scl_fall) begin
                  if (cnt == 4'd8) begin
                    st <= HACK; sda_oe <= 1'b0;
                  end else begin
                    tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
                  end
                end
          HACK: if (scl_rise) hack <= ~sda_s[1];
                else if (scl_fall) begin
                  if (hack) begin
                    st <= RDAT; cnt <= '0; tx <= nxt; sda_oe <= ~nxt[7];
                    req <= 1'b1; code <= EV_RPROC; hold <= 1'b1;
                  end else begin
                    st <= IDLE;
                  end
                end
          default: ;
        endcase
      end
    end
  end

  a_r10_hold_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (req && evt_code != EV_STOP));

  a_r4_event_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cond_start && !cond_stop) |=> (evt_valid && $stable(evt_code) && $stable(evt_wdata)));

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    cond_stop |=> (!sda_oe && !scl_oe && (st == IDLE)));

  a_r3_refused_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ACKP && !is_addr && wr_ref) |-> !sda_oe);

  a_r2_addr_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ACKP && is_addr && fell && !req) |-> sda_oe);

  a_r8_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !stop_p);
endmodule

// File: tb/i2c_evt_target_test.sv
module i2c_evt_target_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl_l = 1'b0, m_sda_l = 1'b0;
  logic scl_oe, sda_oe, evt_valid;
  logic [2:0] evt_code;
  logic [7:0] evt_wdata;
  logic bk_ready = 1'b0, bk_err = 1'b0;
  logic [7:0] bk_rdata = 8'h00;
  wire scl_bus = ~(m_scl_l | scl_oe);
  wire sda_bus = ~(m_sda_l | sda_oe);
  localparam logic [6:0] OWN = 7'h3A;
  localparam int Q = 12;

  i2c_evt_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_wdata(evt_wdata),
    .bk_ready(bk_ready), .bk_err(bk_err), .bk_rdata(bk_rdata));

  int n_run = 0, n_fail = 0;
  int bk_lat = 3, wc = 0, rd_n = 0, ln = 0, stretch = 0;
  logic e_wreq = 1'b0, e_wrcv = 1'b0;
  logic [2:0] lc [0:127];
  logic [7:0] ld [0:127];

  function automatic logic [7:0] rv(int k);
    return 8'h5A + 8'(k * 29);
  endfunction

  always @(posedge clk) begin
    bk_ready <= 1'b0;
    if (scl_oe) stretch <= stretch + 1;
    if (evt_valid && evt_code == 3'd4) begin
      lc[ln] <= 3'd4; ld[ln] <= 8'h00; ln <= ln + 1;
    end else if (evt_valid && !bk_ready) begin
      if (wc >= bk_lat) begin
        wc <= 0; bk_ready <= 1'b1;
        bk_err <= (evt_code == 3'd0) ? e_wreq : (evt_code == 3'd2) ? e_wrcv : 1'b0;
        bk_rdata <= rv(rd_n);
        if (evt_code == 3'd1 || evt_code == 3'd3) rd_n <= rd_n + 1;
        lc[ln] <= evt_code; ld[ln] <= evt_wdata; ln <= ln + 1;
      end else wc <= wc + 1;
    end
  end

  task automatic chk(string r, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic waitq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_bit(input logic b, output logic s);
    m_sda_l = ~b; waitq(Q);
    m_scl_l = 1'b0;
    while (!scl_bus) @(negedge clk);
    waitq(Q); s = sda_bus;
    m_scl_l = 1'b1; waitq(Q);
  endtask

  task automatic i2c_start;
    m_sda_l = 1'b0; m_scl_l = 1'b0; waitq(Q);
    m_sda_l = 1'b1; waitq(Q);
    m_scl_l = 1'b1; waitq(Q);
  endtask

  task automatic i2c_rstart;
    m_sda_l = 1'b0; waitq(Q);
    m_scl_l = 1'b0; while (!scl_bus) @(negedge clk); waitq(Q);
    m_sda_l = 1'b1; waitq(Q);
    m_scl_l = 1'b1; waitq(Q);
  endtask

  task automatic i2c_stop;
    m_sda_l = 1'b1; waitq(Q);
    m_scl_l = 1'b0; while (!scl_bus) @(negedge clk); waitq(Q);
    m_sda_l = 1'b0; waitq(4 * Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s); ack = ~s;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d, output int mid);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); d[i] = s; end
    mid = ln;
    bus_bit(~ack, s);
  endtask

  // {addr, wreq_err, data, wrcv_err, exp_addr_ack, exp_data_ack}
  localparam int NV = 6;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {7'h3A, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1},
    {7'h3A, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0},
    {7'h3A, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0},
    {7'h3B, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0},
    {7'h3A, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {7'h3A, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0}};

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic a; logic [7:0] d; int base, r0, mid, s0, nstop;
    waitq(3);
    chk("R11 sda_oe", sda_oe, 0); chk("R11 scl_oe", scl_oe, 0); chk("R11 evt_valid", evt_valid, 0);
    rst_n = 1'b1; waitq(10);
    chk("R11 idle after reset", {sda_oe, scl_oe, evt_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i]; e_wreq = v[11]; e_wrcv = v[2];
      base = ln;
      i2c_start;
      wr_byte({v[18:12], 1'b0}, a);
      chk("R1 R2 address ack", a, v[1]);
      wr_byte(v[10:3], a);
      chk(v[11] ? "R3 refused nack" : "R4 data ack", a, v[0]);
      i2c_stop;
      if (!v[1]) chk("R2 no events on mismatch", ln - base, 0);
      else if (v[11]) begin
        chk("R3 event count", ln - base, 2);
        chk("R1 write requested", lc[base], 0);
        chk("R3 then stop", lc[base + 1], 4);
      end else begin
        chk("R4 event count", ln - base, 3);
        chk("R1 write requested", lc[base], 0);
        chk("R4 write received", lc[base + 1], 2);
        chk("R4 byte delivered", ld[base + 1], v[10:3]);
        chk("R8 stop event", lc[base + 2], 4);
      end
    end
    e_wreq = 1'b0; e_wrcv = 1'b0;

    base = ln; r0 = rd_n;
    i2c_start;
    wr_byte({OWN, 1'b1}, a); chk("R5 read address ack", a, 1);
    rd_byte(1'b1, d, mid); chk("R5 first byte", d, rv(r0));
    chk("R6 prefetch before host ack", lc[mid - 1], 3);
    rd_byte(1'b1, d, mid); chk("R6 second byte", d, rv(r0 + 1));
    rd_byte(1'b0, d, mid); chk("R6 third byte", d, rv(r0 + 2));
    waitq(4 * Q);
    chk("R7 no event after nack", ln - base, 4);
    chk("R7 sda released after nack", sda_oe, 0);
    i2c_stop;
    chk("R6 event order", {lc[base], lc[base + 1], lc[base + 2], lc[base + 3], lc[base + 4]},
        {3'd1, 3'd3, 3'd3, 3'd3, 3'd4});
    i2c_start;
    wr_byte({OWN, 1'b1}, a);
    rd_byte(1'b0, d, mid);
    chk("R7 prefetched byte dropped", d, rv(r0 + 4));
    i2c_stop;

    base = ln;
    i2c_start;
    wr_byte({OWN, 1'b0}, a);
    wr_byte(8'h42, a); chk("R9 byte before restart", a, 1);
    i2c_rstart;
    wr_byte({OWN, 1'b1}, a); chk("R9 address after restart", a, 1);
    rd_byte(1'b0, d, mid);
    i2c_stop;
    nstop = 0;
    for (int k = base; k < ln; k++) if (lc[k] == 3'd4) nstop++;
    chk("R9 single stop event", nstop, 1);
    chk("R9 event sequence", {lc[base], lc[base + 1], lc[base + 2], lc[base + 3], lc[base + 4]},
        {3'd0, 3'd2, 3'd1, 3'd3, 3'd4});

    base = ln;
    i2c_start;
    wr_byte({OWN, 1'b0}, a);
    bus_bit(1'b1, a); bus_bit(1'b0, a); bus_bit(1'b1, a);
    i2c_stop;
    chk("R8 stop mid byte events", ln - base, 2);
    chk("R8 stop mid byte code", lc[base + 1], 4);
    chk("R8 lines released", {sda_oe, scl_oe}, 0);
    i2c_start;
    wr_byte({OWN, 1'b0}, a); chk("R8 new address after stop", a, 1);
    i2c_stop;

    bk_lat = 300; s0 = stretch; base = ln;
    i2c_start;
    wr_byte({OWN, 1'b0}, a); chk("R10 slow address ack", a, 1);
    wr_byte(8'h9C, a); chk("R10 slow data ack", a, 1);
    i2c_stop;
    chk("R10 scl held while waiting", (stretch - s0) >= 2 * (300 - 3 * Q), 1);
    chk("R10 slow byte delivered", ld[base + 1], 8'h9C);
    chk("R10 released after", scl_oe, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule